// File: doc/BRIEF.md
# Two-Tier Priority Interrupt Controller

This block gathers a bank of interrupt request lines and picks one of them to present to a processor core. Each source carries a two-bit priority level. The lowest source indices are special:

- Indices 0 and 1 are reserved overlays and never compete.
- Indices 2 to 5 are core exceptions pinned to the top level.
- Every other source has a level register that software writes. A level of zero disables that source.

Selection has two tiers. The highest level among pending sources wins first. Among sources at that level, the lowest index wins.

The block drives three outputs toward the core: a pending flag, the winning vector number, and a fetch address. The fetch address is a software-written base plus twice the vector number, because each table entry spans two words. Requests are sampled into a register, and arbitration runs combinationally from that register into registered outputs. While the core holds acknowledge, the outputs stay frozen so that the vector it is taking cannot shift underneath it.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, irqPending is 0, vecNum is 0, vecAddr is 0, the base register is 0, and every programmable level register is 0 (disabled).
- R2: A pending source at a higher effective level always wins over a pending source at a lower level, whatever their indices.
- R3: Among pending sources that share the highest active level, the one with the smallest index wins.
- R4: While irqPending is 1, vecAddr equals base + 2 × vecNum, computed modulo 2^ADDR_W.
- R5: A base write (baseWrEn=1 at an edge) is used by the arbitration result loaded at the following edge. The result loaded at the same edge as the write still uses the old base.
- R6: Sources 2, 3, 4 and 5 always have effective level 3. Level writes (levelWrEn=1 with levelIdx 2..5) to them have no effect.
- R7: Requests on sources 0 and 1 are ignored and never raise irqPending. Level writes to those indices are ignored.
- R8: A programmable source (index 6 and up) whose level register holds 0 never wins and never raises irqPending. A nonzero value 1..3 written through levelWrEn/levelIdx/levelVal enables it at that level.
- R9: While ackIn is 1 at a clock edge, irqPending, vecNum and vecAddr keep their values across that edge.
- R10: A request pattern present on irqReq at edge N is reflected on the outputs after edge N+1, and not after edge N alone.
- R11: When no eligible source is pending, irqPending, vecNum and vecAddr are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| irqReq | input | NUM_SRC | Request lines, one per source index |
| levelWrEn | input | 1 | Write strobe for a source level register |
| levelIdx | input | $clog2(NUM_SRC) | Source index targeted by a level write |
| levelVal | input | 2 | Level value to write (0 disables) |
| baseWrEn | input | 1 | Write strobe for the vector base register |
| baseData | input | ADDR_W | New vector base value |
| ackIn | input | 1 | Core acknowledge; freezes the outputs while high |
| irqPending | output | 1 | An eligible source is selected |
| vecNum | output | $clog2(NUM_SRC) | Index of the selected source |
| vecAddr | output | ADDR_W | Vector fetch address of the selected source |

## Verification
Directed patterns separate the two tiers of selection:

- A low index at a low level is set against a higher index at the top level, which shows that level outranks index.
- Two sources sharing level 3 show the index tie-break.
- A programmable source with level 0, and requests on the reserved indices, show that these never reach the core.
- A pinned exception whose level write was attempted shows that such writes are ignored.

Timing cases check separately the two-edge request latency, the one-edge delay before a base write affects the address, wrap-around of the address sum, and the freeze under acknowledge. A long random phase then mixes sparse requests, level rewrites, base rewrites and acknowledge pulses, and compares every cycle against a reference model kept in the bench.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int LVL_W = 2;
  typedef logic [LVL_W-1:0] level_t;
  localparam level_t LVL_OFF = '0;
  localparam level_t LVL_TOP = '1;

  // strobes from control to datapath
  typedef struct packed {
    logic loadOut;
    logic lvlWr;
    logic baseWr;
  } ctrlStrobes_t;
endpackage

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int NUM_SRC  = 64,
  parameter int RSV_CNT  = 2,
  parameter int FIXED_LO = 2,
  parameter int FIXED_HI = 5,
  localparam int VEC_W   = $clog2(NUM_SRC)
) (
  input  logic             ackIn,
  input  logic             levelWrEn,
  input  logic [VEC_W-1:0] levelIdx,
  input  logic             baseWrEn,
  output ctrlStrobes_t     strb
);
  logic idxReserved;
  logic idxPinned;
  logic idxInRange;

  always_comb begin
    idxReserved = int'(levelIdx) < RSV_CNT;
    idxPinned   = (int'(levelIdx) >= FIXED_LO) && (int'(levelIdx) <= FIXED_HI);
    idxInRange  = int'(levelIdx) < NUM_SRC;
  end

  always_comb begin
    strb.loadOut = !ackIn;
    strb.lvlWr   = levelWrEn && idxInRange && !idxReserved && !idxPinned;
    strb.baseWr  = baseWrEn;
  end
endmodule

// File: rtl/irq_prio_datapath.sv
module irq_prio_datapath
  import irq_prio_pkg::*;
#(
  parameter int NUM_SRC  = 64,
  parameter int ADDR_W   = 16,
  parameter int RSV_CNT  = 2,
  parameter int FIXED_LO = 2,
  parameter int FIXED_HI = 5,
  localparam int VEC_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strb,
  input  logic [NUM_SRC-1:0] irqReq,
  input  logic [VEC_W-1:0]   levelIdx,
  input  level_t             levelVal,
  input  logic [ADDR_W-1:0]  baseData,
  output logic [NUM_SRC-1:0] reqQ,
  output logic [ADDR_W-1:0]  baseQ,
  output logic               irqPending,
  output logic [VEC_W-1:0]   vecNum,
  output logic [ADDR_W-1:0]  vecAddr
);
  level_t            effLvl [NUM_SRC];
  level_t            topLvl;
  logic              winFound;
  logic [VEC_W-1:0]  winVec;
  logic [ADDR_W-1:0] winAddr;

  // registered request vector
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reqQ <= '0;
    else       reqQ <= irqReq;
  end

  // vector base register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            baseQ <= '0;
    else if (strb.baseWr) baseQ <= baseData;
  end

  // effective level per source: reserved, pinned or programmable
  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    if (g < RSV_CNT) begin : gRsv
      assign effLvl[g] = LVL_OFF;
    end else if (g >= FIXED_LO && g <= FIXED_HI) begin : gPin
      assign effLvl[g] = LVL_TOP;
    end else begin : gProg
      level_t lvlQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          lvlQ <= LVL_OFF;
        else if (strb.lvlWr && levelIdx == VEC_W'(g))
          lvlQ <= levelVal;
      end
      assign effLvl[g] = lvlQ;
    end
  end

  // tier one: highest level among pending sources
  always_comb begin
    topLvl = LVL_OFF;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (reqQ[i] && effLvl[i] > topLvl) topLvl = effLvl[i];
    end
  end

  // tier two: lowest index at that level (descending scan, last hit wins)
  always_comb begin
    winFound = topLvl != LVL_OFF;
    winVec   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (winFound && reqQ[i] && effLvl[i] == topLvl) winVec = VEC_W'(i);
    end
    winAddr = baseQ + ADDR_W'({winVec, 1'b0});
  end

  // registered winner, frozen while acknowledge is high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqPending <= 1'b0;
      vecNum     <= '0;
      vecAddr    <= '0;
    end else if (strb.loadOut) begin
      irqPending <= winFound;
      vecNum     <= winFound ? winVec : '0;
      vecAddr    <= winFound ? winAddr : '0;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_prio_pkg::*;
#(
  parameter int NUM_SRC  = 64,
  parameter int ADDR_W   = 16,
  parameter int RSV_CNT  = 2,
  parameter int FIXED_LO = 2,
  parameter int FIXED_HI = 5,
  localparam int VEC_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqReq,
  input  logic               levelWrEn,
  input  logic [VEC_W-1:0]   levelIdx,
  input  logic [1:0]         levelVal,
  input  logic               baseWrEn,
  input  logic [ADDR_W-1:0]  baseData,
  input  logic               ackIn,
  output logic               irqPending,
  output logic [VEC_W-1:0]   vecNum,
  output logic [ADDR_W-1:0]  vecAddr
);
  ctrlStrobes_t       strb;
  logic [NUM_SRC-1:0] reqQ;
  logic [ADDR_W-1:0]  baseQ;

  irq_prio_ctrl #(
    .NUM_SRC(NUM_SRC), .RSV_CNT(RSV_CNT),
    .FIXED_LO(FIXED_LO), .FIXED_HI(FIXED_HI)
  ) u_ctrl (
    .ackIn(ackIn), .levelWrEn(levelWrEn), .levelIdx(levelIdx),
    .baseWrEn(baseWrEn), .strb(strb)
  );

  irq_prio_datapath #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .RSV_CNT(RSV_CNT),
    .FIXED_LO(FIXED_LO), .FIXED_HI(FIXED_HI)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .irqReq(irqReq),
    .levelIdx(levelIdx), .levelVal(levelVal), .baseData(baseData),
    .reqQ(reqQ), .baseQ(baseQ), .irqPending(irqPending),
    .vecNum(vecNum), .vecAddr(vecAddr)
  );
endmodule

// File: rtl/irq_prio_checker.sv
module irq_prio_checker #(
  parameter int NUM_SRC  = 64,
  parameter int ADDR_W   = 16,
  parameter int RSV_CNT  = 2,
  parameter int FIXED_LO = 2,
  parameter int FIXED_HI = 5,
  localparam int VEC_W   = $clog2(NUM_SRC)
) (
  input logic               clk,
  input logic               rstN,
  input logic               ackIn,
  input logic [NUM_SRC-1:0] reqQ,
  input logic [ADDR_W-1:0]  baseQ,
  input logic               irqPending,
  input logic [VEC_W-1:0]   vecNum,
  input logic [ADDR_W-1:0]  vecAddr
);
  logic [NUM_SRC-1:0] reqPrev;
  logic [ADDR_W-1:0]  basePrev;
  logic               ackPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqPrev  <= '0;
      basePrev <= '0;
      ackPrev  <= 1'b0;
    end else begin
      reqPrev  <= reqQ;
      basePrev <= baseQ;
      ackPrev  <= ackIn;
    end
  end

  assert_ack_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    ackIn |=> ($stable(irqPending) && $stable(vecNum) && $stable(vecAddr)));

  assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    !irqPending |-> (vecNum == '0 && vecAddr == '0));

  assert_reserved_out_R7: assert property (@(posedge clk) disable iff (!rstN)
    irqPending |-> int'(vecNum) >= RSV_CNT);

  assert_addr_sum_R4: assert property (@(posedge clk) disable iff (!rstN)
    (irqPending && !ackPrev) |-> vecAddr == basePrev + ADDR_W'({vecNum, 1'b0}));

  assert_winner_asked_R10: assert property (@(posedge clk) disable iff (!rstN)
    (irqPending && !ackPrev) |-> reqPrev[vecNum]);

  assert_pinned_first_R6: assert property (@(posedge clk) disable iff (!rstN)
    (irqPending && !ackPrev && int'(vecNum) > FIXED_HI) |-> reqPrev[FIXED_HI:FIXED_LO] == '0);
endmodule

bind prio_irq_ctrl irq_prio_checker #(
  .NUM_SRC(64), .ADDR_W(16), .RSV_CNT(2), .FIXED_LO(2), .FIXED_HI(5)
) u_chk (
  .clk(clk), .rstN(rstN), .ackIn(ackIn), .reqQ(reqQ), .baseQ(baseQ),
  .irqPending(irqPending), .vecNum(vecNum), .vecAddr(vecAddr)
);

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  localparam int NS = 64;
  localparam int AW = 16;
  localparam int VW = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NS-1:0] irqReq = '0;
  logic          levelWrEn = 1'b0;
  logic [VW-1:0] levelIdx = '0;
  logic [1:0]    levelVal = '0;
  logic          baseWrEn = 1'b0;
  logic [AW-1:0] baseData = '0;
  logic          ackIn = 1'b0;
  logic          irqPending;
  logic [VW-1:0] vecNum;
  logic [AW-1:0] vecAddr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .levelWrEn(levelWrEn),
    .levelIdx(levelIdx), .levelVal(levelVal), .baseWrEn(baseWrEn),
    .baseData(baseData), .ackIn(ackIn), .irqPending(irqPending),
    .vecNum(vecNum), .vecAddr(vecAddr)
  );

  // reference model built from the requirements
  logic [NS-1:0] reqM;
  logic [1:0]    lvlM [NS];
  logic [AW-1:0] baseM;
  logic          expPend;
  logic [VW-1:0] expVec;
  logic [AW-1:0] expAddr;

  function automatic logic [AW+VW:0] pick(input logic [NS-1:0] r,
                                          input logic [1:0] lv [NS],
                                          input logic [AW-1:0] b);
    int best = -1;
    int bestL = 0;
    for (int i = 0; i < NS; i++) begin
      int e;
      if (i < 2) e = 0;
      else if (i <= 5) e = 3;
      else e = int'(lv[i]);
      if (r[i] && e > bestL) begin
        bestL = e;
        best = i;
      end
    end
    if (best < 0) return '0;
    return {1'b1, VW'(best), AW'(b + AW'(2 * best))};
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqM <= '0; baseM <= '0;
      expPend <= 1'b0; expVec <= '0; expAddr <= '0;
      for (int i = 0; i < NS; i++) lvlM[i] <= 2'd0;
    end else begin
      if (!ackIn) {expPend, expVec, expAddr} <= pick(reqM, lvlM, baseM);
      reqM <= irqReq;
      if (levelWrEn && levelIdx > 6'd5) lvlM[levelIdx] <= levelVal;
      if (baseWrEn) baseM <= baseData;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setLvl(input int idx, input logic [1:0] v);
    levelWrEn = 1'b1; levelIdx = VW'(idx); levelVal = v;
    step(1);
    levelWrEn = 1'b0;
  endtask

  task automatic setBase(input logic [AW-1:0] b);
    baseWrEn = 1'b1; baseData = b;
    step(1);
    baseWrEn = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [NS-1:0] bits(input int a, input int b = -1, input int c = -1);
    logic [NS-1:0] v = '0;
    v[a] = 1'b1;
    if (b >= 0) v[b] = 1'b1;
    if (c >= 0) v[c] = 1'b1;
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    void'($urandom(32'd1234));
    step(3);
    rstN = 1'b1;
    step(1);
    chk("R1 pending", irqPending, 0);
    chk("R1 vecNum", vecNum, 0);
    chk("R1 vecAddr", vecAddr, 0);

    irqReq = bits(10); step(2);
    chk("R1 R8 level reset disables", irqPending, 0);

    irqReq = bits(0, 1); step(2);
    chk("R7 reserved ignored", irqPending, 0);
    setLvl(1, 2'd3); step(1);
    chk("R7 reserved level write ignored", irqPending, 0);

    irqReq = '0;
    setLvl(10, 2'd1); setLvl(20, 2'd3); setLvl(30, 2'd3);
    setBase(16'h0100);
    irqReq = bits(10, 20, 30); step(2);
    chk("R3 tie lowest index", vecNum, 20);
    chk("R4 address", vecAddr, 16'h0128);
    irqReq = bits(10, 30); step(2);
    chk("R2 level beats index", vecNum, 30);

    irqReq = '0; step(2);
    chk("R11 idle pending", irqPending, 0);
    chk("R11 idle vec", vecNum, 0);
    chk("R11 idle addr", vecAddr, 0);

    irqReq = bits(10); step(1);
    chk("R10 not after one edge", irqPending, 0);
    step(1);
    chk("R10 after two edges", irqPending, 1);
    chk("R10 vec", vecNum, 10);

    irqReq = '0; setLvl(4, 2'd0);
    irqReq = bits(4, 20); step(2);
    chk("R6 pinned stays enabled", vecNum, 4);
    chk("R6 address", vecAddr, 16'h0108);

    setBase(16'hFFFE);
    chk("R5 old base at write edge", vecAddr, 16'h0108);
    step(1);
    chk("R5 R4 new base wraps", vecAddr, 16'h0006);

    irqReq = bits(40); step(2);
    chk("R8 zero level blocks", irqPending, 0);
    setLvl(40, 2'd2); step(1);
    chk("R8 enabled after write", vecNum, 40);

    irqReq = bits(4); step(2);
    ackIn = 1'b1; irqReq = bits(40); step(3);
    chk("R9 hold vec", vecNum, 4);
    chk("R9 hold addr", vecAddr, 16'h0006);
    ackIn = 1'b0; step(1);
    chk("R9 release vec", vecNum, 40);
    chk("R9 release addr", vecAddr, 16'h004E);

    for (int n = 0; n < 4000; n++) begin
      chk("R2/R3/R4/R9 model pending", irqPending, expPend);
      chk("R2/R3/R4/R9 model vec", vecNum, expVec);
      chk("R2/R3/R4/R9 model addr", vecAddr, expAddr);
      for (int i = 0; i < NS; i++) irqReq[i] = ($urandom % 16) == 0;
      levelWrEn = ($urandom % 4) == 0;
      levelIdx  = VW'($urandom);
      levelVal  = 2'($urandom);
      baseWrEn  = ($urandom % 16) == 0;
      baseData  = AW'($urandom);
      ackIn     = ($urandom % 5) == 0;
      step(1);
    end
    finishRun();
  end
endmodule